// File: doc/BRIEF.md
# Serially Programmed Clock Fan-out with Per-Output Gating

The block distributes one reference clock to six output pairs and one feedback output. A two-wire serial slave inside the block accepts write transfers from a host. Two of the received bytes carry one enable bit per output pair and one for the feedback output. Every enable is moved into the reference clock domain and applied at a clock phase where the gated output is already low, so enabling or disabling an output never produces a shortened pulse.

A mode pin decides what the second leg of each pair carries. In complementary mode it carries an inverted copy of the reference. In identical mode it carries the same true copy as the first leg. An active-low power-down pin overrides the register contents and forces every output low.

The serial lines are oversampled by a system clock. START, STOP and the data bits are recovered from the edges of the synchronized lines. The slave only receives; it acknowledges by pulling its data line low.

Top module: `clk_fanout_gate`

## Requirements
- R1: An address byte is acknowledged only when its upper seven bits equal 1101001 and its last bit (read/write) is 0. Any other address byte gets no acknowledge, and the rest of that transfer is ignored.
- R2: After an acknowledged address, the slave acknowledges every data byte. It drives the acknowledge only while the serial clock is low, and holds its drive steady while the serial clock is high.
- R3: Data bits arrive MSB first. The data byte at index 7 (the first data byte is index 0) controls the pairs: bit 0 enables pair 0, bit 2 pair 1, bit 5 pair 2 and bit 6 pair 3.
- R4: The data byte at index 6 controls the rest: bit 1 enables pair 4, bit 3 enables pair 5 and bit 4 enables the feedback output.
- R5: Data bytes at indices 0 to 5 and above 7 have no effect on any output. Bits 1, 3, 4 and 7 of byte 7 and bits 0, 2, 5, 6 and 7 of byte 6 have no effect either.
- R6: After reset every output is enabled.
- R7: While the power-down input is 0, all thirteen clock outputs are 0.
- R8: With the mode input at 1, the second leg of each enabled pair is the inverse of the reference clock. With it at 0, both legs of a pair carry the true reference clock.
- R9: A disabled output stays at 0 on both legs. A true-copy output is high only while the reference clock is high.
- R10: A STOP or a repeated START ends the transfer. A byte with fewer than 8 bits received is never committed, and a transfer that begins with a repeated START counts its data bytes again from index 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock that oversamples the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls the serial data line low (acknowledge) |
| ref_clk_i | input | 1 | Reference clock to distribute |
| pd_n_i | input | 1 | Active-low power-down |
| comp_mode_i | input | 1 | 1: second leg inverted; 0: second leg true |
| clk_t_o | output | 6 | True leg of each pair |
| clk_c_o | output | 6 | Second leg of each pair |
| clk_fb_o | output | 1 | Feedback output, true copy |

## Verification
A vector sweep sets each enable bit alone and then all reserved bits alone. A design that swapped or shifted the sparse bit positions, or that let a reserved bit gate an output, turns on the wrong pair or turns off an output that should stay on. A STOP in the middle of a byte and a repeated START catch a design that commits half-received bytes or keeps counting byte indices across transfers; either one would disable pairs. A wrong address, a read-direction address and bytes written beyond index 7 must change nothing. In complementary mode, each output is sampled in both reference phases, which shows whether a disabled second leg sits high instead of low.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;
  localparam int NUM_PAIRS  = 6;
  localparam int NUM_EN     = NUM_PAIRS + 1;
  localparam int IDX_W      = 4;
  localparam int IDX_SAT    = 8;
  localparam int REG_BASE   = 6;
  localparam int NUM_REGS   = 2;
  localparam logic [6:0] SLV_ADDR = 7'b1101001;

  typedef enum logic [2:0] {
    SM_IDLE, SM_ADDR, SM_ACK_WAIT, SM_ACK, SM_DATA
  } smb_state_e;

  // config register (relative to REG_BASE) holding enable i
  function automatic int en_reg(int i);
    return (i < 4) ? 1 : 0;
  endfunction

  function automatic int en_bit(int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 5;
      3: return 6;
      4: return 1;
      5: return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/smb_slave.sv
module smb_slave
  import clk_gate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  output logic             wr_vld_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic [7:0]       wr_data_o
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_p, sda_p, scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;
  smb_state_e st_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] sh_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0] sh_nxt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_p <= scl_q[SYNC_STAGES-1];
      sda_p <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_q[SYNC_STAGES-1];
  assign sda_s     = sda_q[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign start_det = scl_s & scl_p & sda_p & ~sda_s;
  assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
  assign sh_nxt    = {sh_q[6:0], sda_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= SM_IDLE;
      bit_cnt_q <= '0;
      sh_q      <= '0;
      idx_q     <= '0;
      sda_oe_o  <= 1'b0;
      wr_vld_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_vld_o <= 1'b0;
      if (start_det) begin
        st_q      <= SM_ADDR;
        bit_cnt_q <= '0;
        idx_q     <= '0;
        sda_oe_o  <= 1'b0;
      end else if (stop_det) begin
        st_q     <= SM_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (st_q)
          SM_ADDR: if (scl_rise) begin
            sh_q      <= sh_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7)
              st_q <= (sh_nxt == {SLV_ADDR, 1'b0}) ? SM_ACK_WAIT : SM_IDLE;
          end
          SM_ACK_WAIT: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            st_q     <= SM_ACK;
          end
          SM_ACK: if (scl_fall) begin
            sda_oe_o  <= 1'b0;
            bit_cnt_q <= '0;
            st_q      <= SM_DATA;
          end
          SM_DATA: if (scl_rise) begin
            sh_q      <= sh_nxt;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              wr_vld_o  <= 1'b1;
              wr_idx_o  <= idx_q;
              wr_data_o <= sh_nxt;
              if (idx_q != IDX_W'(IDX_SAT)) idx_q <= idx_q + 1'b1;
              st_q <= SM_ACK_WAIT;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/en_regfile.sv
module en_regfile
  import clk_gate_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_vld_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [7:0]        wr_data_i,
  output logic [NUM_EN-1:0] en_o
);
  logic [7:0] cfg_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        cfg_q[r] <= 8'hFF;
      else if (wr_vld_i && wr_idx_i == IDX_W'(REG_BASE + r))
        cfg_q[r] <= wr_data_i;
    end
  end

  for (genvar e = 0; e < NUM_EN; e++) begin : g_map
    assign en_o[e] = cfg_q[en_reg(e)][en_bit(e)];
  end
endmodule

// File: rtl/clk_leg_gate.sv
module clk_leg_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic inv_i,
  input  logic pd_n_i,
  output logic clk_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic gate_neg_q, gate_pos_q;

  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '1;
    else         sync_q <= {sync_q[SYNC_STAGES-2:0], en_i};
  end

  // true leg is low after the falling edge
  always_ff @(negedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_neg_q <= 1'b1;
    else         gate_neg_q <= sync_q[SYNC_STAGES-1];
  end

  // inverted leg is low after the rising edge
  always_ff @(posedge ref_clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_pos_q <= 1'b1;
    else         gate_pos_q <= sync_q[SYNC_STAGES-1];
  end

  assign clk_o = pd_n_i & (inv_i ? (~ref_clk_i & gate_pos_q)
                                 : (ref_clk_i & gate_neg_q));
endmodule

// File: rtl/clk_fanout_gate.sv
module clk_fanout_gate
  import clk_gate_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 scl_i,
  input  logic                 sda_i,
  output logic                 sda_oe_o,
  input  logic                 ref_clk_i,
  input  logic                 pd_n_i,
  input  logic                 comp_mode_i,
  output logic [NUM_PAIRS-1:0] clk_t_o,
  output logic [NUM_PAIRS-1:0] clk_c_o,
  output logic                 clk_fb_o
);
  logic             wr_vld;
  logic [IDX_W-1:0] wr_idx;
  logic [7:0]       wr_data;
  logic [NUM_EN-1:0] en;

  smb_slave #(.SYNC_STAGES(2)) u_slave (
    .clk_i, .rst_ni, .scl_i, .sda_i, .sda_oe_o,
    .wr_vld_o(wr_vld), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
  );

  en_regfile u_regs (
    .clk_i, .rst_ni,
    .wr_vld_i(wr_vld), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .en_o(en)
  );

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    clk_leg_gate u_t (
      .ref_clk_i, .rst_ni, .en_i(en[p]), .inv_i(1'b0),
      .pd_n_i, .clk_o(clk_t_o[p])
    );
    clk_leg_gate u_c (
      .ref_clk_i, .rst_ni, .en_i(en[p]), .inv_i(comp_mode_i),
      .pd_n_i, .clk_o(clk_c_o[p])
    );
  end

  clk_leg_gate u_fb (
    .ref_clk_i, .rst_ni, .en_i(en[NUM_PAIRS]), .inv_i(1'b0),
    .pd_n_i, .clk_o(clk_fb_o)
  );
endmodule

// File: rtl/clk_fanout_gate_chk.sv
module clk_fanout_gate_chk
  import clk_gate_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 scl_i,
  input logic                 sda_oe_o,
  input logic                 ref_clk_i,
  input logic                 pd_n_i,
  input logic                 comp_mode_i,
  input logic [NUM_PAIRS-1:0] clk_t_o,
  input logic [NUM_PAIRS-1:0] clk_c_o,
  input logic                 clk_fb_o
);
  AST_PD_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pd_n_i |-> (clk_t_o == '0 && clk_c_o == '0 && !clk_fb_o)); // R7

  AST_SAME_LEGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !comp_mode_i |-> clk_c_o == clk_t_o); // R8

  AST_LEGS_DISJOINT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    comp_mode_i |-> (clk_t_o & clk_c_o) == '0); // R8

  AST_TRUE_FOLLOWS_REF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_clk_i |-> (clk_t_o == '0 && !clk_fb_o)); // R9

  AST_ACK_ON_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_i); // R2

  AST_ACK_QUIET_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3))
      |-> $stable(sda_oe_o)); // R2
endmodule

bind clk_fanout_gate clk_fanout_gate_chk u_chk (.*);

// File: tb/clk_fanout_gate_bench.sv
module clk_fanout_gate_bench;
  localparam int Q = 8;

  logic clk = 1'b0, ref_clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_drv = 1'b1, pd_n = 1'b1, comp_mode = 1'b1;
  logic sda_oe, sda_bus, fb;
  logic [5:0] t_o, c_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;
  always #18 ref_clk = ~ref_clk;
  assign sda_bus = sda_drv & ~sda_oe;

  clk_fanout_gate u_clk_fanout_gate (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .ref_clk_i(ref_clk), .pd_n_i(pd_n),
    .comp_mode_i(comp_mode), .clk_t_o(t_o), .clk_c_o(c_o), .clk_fb_o(fb)
  );

  // {byte6, byte7, expected {fb, pair5..pair0}}
  localparam logic [22:0] VEC [0:10] = '{
    {8'h00, 8'h00, 7'b0000000},
    {8'hFF, 8'hFF, 7'b1111111},
    {8'h00, 8'h01, 7'b0000001},
    {8'h00, 8'h04, 7'b0000010},
    {8'h00, 8'h20, 7'b0000100},
    {8'h00, 8'h40, 7'b0001000},
    {8'h02, 8'h00, 7'b0010000},
    {8'h08, 8'h00, 7'b0100000},
    {8'h10, 8'h00, 7'b1000000},
    {8'hE5, 8'h9A, 7'b0000000},
    {8'h1A, 8'h65, 7'b1111111}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wq(); scl = 1'b1; wq(); sda_drv = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wq(); scl = 1'b1; wq(); sda_drv = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wq(); scl = 1'b1; wq(); scl = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_drv = 1'b1; wq(); scl = 1'b1; wq();
    ack = ~sda_bus;
    scl = 1'b0; wq();
  endtask

  task automatic write_block(input logic [7:0] b6, input logic [7:0] b7, input int extra);
    logic ack, all_ack;
    bus_start();
    send_byte(8'hD2, ack);
    chk("R1 address ack", ack, 1'b1);
    all_ack = 1'b1;
    for (int i = 0; i < 6; i++) begin
      send_byte(8'h00, ack); all_ack &= ack;
    end
    send_byte(b6, ack); all_ack &= ack;
    send_byte(b7, ack); all_ack &= ack;
    for (int i = 0; i < extra; i++) begin
      send_byte(8'h00, ack); all_ack &= ack;
    end
    chk("R2 data acks", all_ack, 1'b1);
    bus_stop();
  endtask

  task automatic check_outs(input logic [6:0] exp, input string tag);
    repeat (4) @(posedge ref_clk);
    @(posedge ref_clk); #5;
    chk({tag, " high"}, {fb, t_o, c_o}, {exp[6], exp[5:0], comp_mode ? 6'b0 : exp[5:0]});
    @(negedge ref_clk); #5;
    chk({tag, " low"}, {fb, t_o, c_o}, {1'b0, 6'b0, comp_mode ? exp[5:0] : 6'b0});
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    logic ack;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_outs(7'h7F, "R6 reset");

    for (int v = 0; v < 11; v++) begin
      write_block(VEC[v][22:15], VEC[v][14:7], 0);
      check_outs(VEC[v][6:0], "R3/R4/R5/R9 vector");
    end

    // wrong address, then data that would disable everything
    bus_start();
    send_byte(8'hD4, ack);
    chk("R1 wrong address nack", ack, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(8'h00, ack);
    bus_stop();
    check_outs(7'h7F, "R1 wrong address ignored");

    bus_start();
    send_byte(8'hD3, ack);
    chk("R1 read bit nack", ack, 1'b0);
    for (int i = 0; i < 8; i++) send_byte(8'h00, ack);
    bus_stop();
    check_outs(7'h7F, "R1 read transfer ignored");

    write_block(8'hFF, 8'hFF, 3);
    check_outs(7'h7F, "R5 bytes past 7");

    // half byte 7 then STOP
    bus_start();
    send_byte(8'hD2, ack);
    for (int i = 0; i < 6; i++) send_byte(8'h00, ack);
    send_byte(8'hFF, ack);
    send_bits(8'h00, 4);
    bus_stop();
    check_outs(7'h7F, "R10 partial byte");

    // repeated START restarts byte index
    bus_start();
    send_byte(8'hD2, ack);
    for (int i = 0; i < 6; i++) send_byte(8'h00, ack);
    send_byte(8'hFF, ack);
    send_bits(8'h00, 3);
    bus_start();
    send_byte(8'hD2, ack);
    chk("R10 address after repeated start", ack, 1'b1);
    send_byte(8'h00, ack);
    send_byte(8'h00, ack);
    bus_stop();
    check_outs(7'h7F, "R10 repeated start");

    @(negedge clk); pd_n = 1'b0;
    check_outs(7'h00, "R7 power down");
    @(negedge clk); pd_n = 1'b1;
    check_outs(7'h7F, "R7 power restored");

    write_block(8'h10, 8'h21, 0);
    @(negedge clk); comp_mode = 1'b0;
    check_outs(7'b1000101, "R8 identical legs");
    @(negedge clk); comp_mode = 1'b1;
    check_outs(7'b1000101, "R8 complementary legs");

    report();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    report();
  end
endmodule